// File: doc/BRIEF.md
# Two-Speed Oscillator Start-Up Sequencer

This block decides which oscillator should clock the core after a power-on reset or a wake from sleep. The core starts at once on the internal oscillator, whose speed is set by a 3-bit frequency select. A start-up timer in the external-clock domain meanwhile counts edges of the external oscillator. When it has seen enough edges, the sequencer marks the external source ready and requests the switch to it.

The sequencer runs on the internal (system) clock. The timer runs on the external clock and is controlled through a level enable with an acknowledge, carried across by multi-flop synchronizers in each direction. A wake pulse restarts the whole sequence from any state. The switch request feeds an external glitch-free clock multiplexer. If the configuration selects the internal oscillator only, the timer stays idle and no switch is ever requested. All pins are plain control and status levels, so there is no valid/ready handshake.

Top module: `twospd_startup`

## Requirements
- R1: While `rst_n` is low and on the first cycles after it rises, `osc_ready` and `clk_sel_ext` are 0 and `int_freq` is 3'b000.
- R2: `int_freq` equals the value `freq_sel` had at the previous rising edge of `clk_sys`, at all times after reset.
- R3: After a trigger with `use_ext`=1, `osc_ready` rises no sooner than `OST_CYCLES` (default 1024) rising edges of `clk_ext` after the trigger, and no later than `OST_CYCLES`+64 such edges.
- R4: `osc_ready` and `clk_sel_ext` rise in the same cycle and stay high until the next trigger.
- R5: `ost_busy` is 1 while the timer is counting and 0 once `osc_ready` is 1. `osc_ready` only rises in the cycle after a cycle with `ost_busy`=1.
- R6: A `wake` high at a rising edge of `clk_sys` clears `osc_ready`, `clk_sel_ext` and `ost_busy` from that edge onward.
- R7: If `use_ext`=0 when the sequence restarts, the timer is not started: `ost_busy`, `osc_ready` and `clk_sel_ext` stay 0 until the next trigger.
- R8: Changes to `use_ext` after the sequence has left its clearing step have no effect until the next trigger.
- R9: While `clk_ext` has no edges, `osc_ready` stays 0 and `ost_busy` stays 1. Once edges arrive, the count completes.
- R10: A wake during a count discards the partial count. The new count again needs at least `OST_CYCLES` external edges after that wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | Internal oscillator clock; clocks the sequencer |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| wake | input | 1 | Wake-from-sleep pulse, synchronous to `clk_sys`, restarts the sequence |
| clk_ext | input | 1 | External oscillator clock counted by the start-up timer |
| use_ext | input | 1 | Configured source: 1 = external oscillator, 0 = internal only |
| freq_sel | input | 3 | Internal oscillator frequency select |
| clk_sel_ext | output | 1 | Request to the clock multiplexer to switch to the external clock |
| osc_ready | output | 1 | Status: 1 = external oscillator proven stable, 0 = running from internal |
| ost_busy | output | 1 | Status: start-up timer is counting |
| int_freq | output | 3 | Registered frequency select driven to the internal oscillator divider |

## Verification
The main sequence is run from a table: fast, slow and medium external clocks with the external source selected, and one row with the internal source only. The fast and slow rows check that the edge-count window holds whichever clock is faster. The internal-only row separates "timer never started" from "timer started late". Directed runs cover a stopped external clock, which tells a count gated by real edges from one timed on the system clock. They also cover a wake in mid-count, which shows whether a partial count is wrongly credited, and toggling `use_ext` after the trigger, which shows whether the configuration is latched at the right step.

// File: rtl/tss_pkg.sv
package tss_pkg;
  typedef enum logic [1:0] {
    SEQ_CLEAR   = 2'd0,
    SEQ_COUNT   = 2'd1,
    SEQ_READY   = 2'd2,
    SEQ_INTONLY = 2'd3
  } seq_state_t;
endpackage

// File: rtl/tss_sync.sv
module tss_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/tss_ost_timer.sv
module tss_ost_timer #(
  parameter int CYCLES      = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_ext,
  input  logic rst_n,
  input  logic en_async,
  output logic ack,
  output logic done
);
  localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic          en_s;
  logic [CW-1:0] cnt;

  tss_sync #(.W(1), .STAGES(SYNC_STAGES)) u_en_sync (
    .clk   (clk_ext),
    .rst_n (rst_n),
    .d     (en_async),
    .q     (en_s)
  );

  always_ff @(posedge clk_ext or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!en_s) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (cnt == LAST) done <= 1'b1;
      else             cnt  <= cnt + 1'b1;
    end
  end

  assign ack = en_s;
endmodule

// File: rtl/tss_seq.sv
module tss_seq
  import tss_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wake,
  input  logic       use_ext,
  input  logic       ack_s,
  input  logic       done_s,
  output seq_state_t state
);
  seq_state_t nxt;

  always_comb begin
    nxt = state;
    if (wake) begin
      nxt = SEQ_CLEAR;
    end else begin
      unique case (state)
        SEQ_CLEAR: begin
          if (!use_ext)              nxt = SEQ_INTONLY;
          else if (!ack_s && !done_s) nxt = SEQ_COUNT;
        end
        SEQ_COUNT:   if (done_s) nxt = SEQ_READY;
        SEQ_READY:   nxt = SEQ_READY;
        SEQ_INTONLY: nxt = SEQ_INTONLY;
        default:     nxt = SEQ_CLEAR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEQ_CLEAR;
    else        state <= nxt;
  end
endmodule

// File: rtl/twospd_startup.sv
module twospd_startup
  import tss_pkg::*;
#(
  parameter int OST_CYCLES  = 1024,
  parameter int SYNC_STAGES = 2,
  parameter int FREQ_W      = 3
) (
  input  logic              clk_sys,
  input  logic              rst_n,
  input  logic              wake,
  input  logic              clk_ext,
  input  logic              use_ext,
  input  logic [FREQ_W-1:0] freq_sel,
  output logic              clk_sel_ext,
  output logic              osc_ready,
  output logic              ost_busy,
  output logic [FREQ_W-1:0] int_freq
);
  seq_state_t state;
  logic       ost_en;
  logic       ack_x, done_x;
  logic [1:0] back_s;

  assign ost_en = (state == SEQ_COUNT) || (state == SEQ_READY);

  tss_ost_timer #(.CYCLES(OST_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_timer (
    .clk_ext  (clk_ext),
    .rst_n    (rst_n),
    .en_async (ost_en),
    .ack      (ack_x),
    .done     (done_x)
  );

  tss_sync #(.W(2), .STAGES(SYNC_STAGES)) u_back_sync (
    .clk   (clk_sys),
    .rst_n (rst_n),
    .d     ({ack_x, done_x}),
    .q     (back_s)
  );

  tss_seq u_seq (
    .clk     (clk_sys),
    .rst_n   (rst_n),
    .wake    (wake),
    .use_ext (use_ext),
    .ack_s   (back_s[1]),
    .done_s  (back_s[0]),
    .state   (state)
  );

  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n) int_freq <= '0;
    else        int_freq <= freq_sel;
  end

  assign osc_ready   = (state == SEQ_READY);
  assign clk_sel_ext = (state == SEQ_READY);
  assign ost_busy    = (state == SEQ_COUNT);
endmodule

// File: rtl/twospd_startup_chk.sv
module twospd_startup_chk #(
  parameter int FREQ_W = 3
) (
  input logic              clk_sys,
  input logic              rst_n,
  input logic              wake,
  input logic [FREQ_W-1:0] freq_sel,
  input logic [FREQ_W-1:0] int_freq,
  input logic              osc_ready,
  input logic              clk_sel_ext,
  input logic              ost_busy
);
  logic past_ok;

  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_FREQ_FOLLOW: assert property (@(posedge clk_sys) disable iff (!rst_n)
    past_ok |-> int_freq == $past(freq_sel)); // R2

  AST_READY_STICKY: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (osc_ready && !wake) |=> (osc_ready && clk_sel_ext)); // R4

  AST_BUSY_BEFORE_READY: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (past_ok && $rose(osc_ready)) |-> $past(ost_busy)); // R5

  AST_WAKE_CLEARS: assert property (@(posedge clk_sys) disable iff (!rst_n)
    wake |=> (!osc_ready && !clk_sel_ext && !ost_busy)); // R6

  AST_SEL_WITH_READY: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (past_ok && $rose(clk_sel_ext)) |-> $rose(osc_ready)); // R4
endmodule

bind twospd_startup twospd_startup_chk #(.FREQ_W(FREQ_W)) u_chk (.*);

// File: tb/twospd_startup_bench.sv
`timescale 1ns/1ps
module twospd_startup_bench;
  localparam int OSTC   = 1024;
  localparam int MARGIN = 64;

  logic       clk_sys = 1'b0;
  logic       clk_ext = 1'b0;
  logic       rst_n   = 1'b0;
  logic       wake    = 1'b0;
  logic       use_ext = 1'b1;
  logic [2:0] freq_sel = 3'b000;
  logic       clk_sel_ext, osc_ready, ost_busy;
  logic [2:0] int_freq;

  int  ext_half = 5;
  bit  ext_on   = 1'b1;
  int  ext_edges = 0;
  int  total = 0;
  int  bad   = 0;

  twospd_startup u_twospd_startup (
    .clk_sys, .rst_n, .wake, .clk_ext, .use_ext, .freq_sel,
    .clk_sel_ext, .osc_ready, .ost_busy, .int_freq
  );

  always #10 clk_sys = ~clk_sys;
  always begin
    #(ext_half);
    if (ext_on) clk_ext = ~clk_ext;
  end
  always @(posedge clk_ext) ext_edges++;

  // row: {use_ext, ext_half[5:0], freq[2:0], exp_ready}
  localparam int NROW = 4;
  localparam logic [10:0] ROWS [NROW] = '{
    {1'b1, 6'd5,  3'b101, 1'b1},
    {1'b1, 6'd17, 3'b010, 1'b1},
    {1'b0, 6'd5,  3'b111, 1'b0},
    {1'b1, 6'd8,  3'b000, 1'b1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_wake();
    @(negedge clk_sys); wake = 1'b1;
    @(negedge clk_sys); wake = 1'b0;
  endtask

  task automatic wait_ready(input int limit, input int mark, output bit got, output int edges);
    got = 1'b0;
    edges = 0;
    for (int k = 0; k < limit; k++) begin
      @(negedge clk_sys);
      if (osc_ready) begin
        got = 1'b1;
        edges = ext_edges - mark;
        break;
      end
    end
  endtask

  task automatic hold_quiet(input int cycles, input string req, output int seen);
    seen = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk_sys);
      if (osc_ready || clk_sel_ext || ost_busy) seen++;
    end
    check(seen == 0, req, seen, 0);
  endtask

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit got; int edges; int mark; int seen;
    // R1: reset state
    repeat (4) @(negedge clk_sys);
    check(!osc_ready && !clk_sel_ext, "R1 reset outputs", {osc_ready, clk_sel_ext}, 0);
    check(int_freq == 3'b000, "R1 reset freq", int_freq, 0);
    rst_n = 1'b1; mark = ext_edges;
    @(negedge clk_sys);
    check(!osc_ready && !clk_sel_ext, "R1 after release", osc_ready, 0);
    wait_ready(3000, mark, got, edges);
    check(got && edges >= OSTC && edges <= OSTC + MARGIN, "R3 power-on window", edges, OSTC);
    check(clk_sel_ext, "R4 select with ready", clk_sel_ext, 1);

    // table walk
    for (int r = 0; r < NROW; r++) begin
      @(negedge clk_sys);
      use_ext  = ROWS[r][10];
      ext_half = int'(ROWS[r][9:4]);
      freq_sel = ROWS[r][3:1];
      @(negedge clk_sys);
      check(int_freq == ROWS[r][3:1], "R2 freq follows", int_freq, ROWS[r][3:1]);
      @(negedge clk_sys); wake = 1'b1; mark = ext_edges;
      @(negedge clk_sys); wake = 1'b0;
      check(!osc_ready && !clk_sel_ext, "R6 wake clears", osc_ready, 0);
      if (ROWS[r][0]) begin
        repeat (20) @(negedge clk_sys);
        check(ost_busy, "R5 busy while counting", ost_busy, 1);
        wait_ready(3000, mark, got, edges);
        check(got && edges >= OSTC && edges <= OSTC + MARGIN, "R3 table window", edges, OSTC);
        check(!ost_busy && clk_sel_ext, "R5 busy low when ready", ost_busy, 0);
        repeat (50) @(negedge clk_sys);
        check(osc_ready && clk_sel_ext, "R4 ready held", osc_ready, 1);
      end else begin
        hold_quiet(1500, "R7 internal only quiet", seen);
      end
    end

    // R8: use_ext dropped after trigger is ignored
    ext_half = 5; use_ext = 1'b1;
    pulse_wake(); mark = ext_edges;
    repeat (10) @(negedge clk_sys);
    use_ext = 1'b0;
    wait_ready(3000, mark, got, edges);
    check(got, "R8 drop ignored", got, 1);
    // R8: use_ext raised after internal-only trigger is ignored
    pulse_wake();
    repeat (10) @(negedge clk_sys);
    use_ext = 1'b1;
    hold_quiet(1500, "R8 raise ignored", seen);

    // R9: stopped external clock
    ext_on = 1'b0;
    pulse_wake();
    repeat (2000) @(negedge clk_sys);
    check(!osc_ready, "R9 stays internal", osc_ready, 0);
    check(ost_busy, "R9 timer waiting", ost_busy, 1);
    ext_on = 1'b1; mark = ext_edges;
    wait_ready(3000, mark, got, edges);
    check(got && edges >= OSTC - 4, "R9 completes after restart of edges", edges, OSTC);

    // R10: wake mid-count discards partial count
    pulse_wake();
    repeat (250) @(negedge clk_sys);
    check(ost_busy && !osc_ready, "R10 mid count", osc_ready, 0);
    @(negedge clk_sys); wake = 1'b1; mark = ext_edges;
    @(negedge clk_sys); wake = 1'b0;
    wait_ready(3000, mark, got, edges);
    check(got && edges >= OSTC && edges <= OSTC + MARGIN, "R10 full recount", edges, OSTC);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule